// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Gap Framing

This block turns a two-rail return-to-zero serial stream into 32-bit parallel words. One input rail pulses for a logic One and the other pulses for a logic Zero. When both rails are low, the line is null. A bit is taken each time the line leaves null for a valid rail. The bits are shifted into a word register. The first bit to arrive ends up in the least significant position.

The block has no word-length framing. A word ends only when the line stays idle for a set number of rising edges of a separate, slower gap clock. At that point the block does three things:

- It pulses a load strobe for one cycle.
- It presents the assembled word.
- It raises an error flag if the bit count was not 32, or if odd parity was enabled and failed.

On a parity failure, the top bit of the delivered word is forced high as a marker. After reset, the receiver ignores the line until it has seen one full gap. This prevents a word that was already in progress from being delivered half-received.

All inputs are resynchronised into the fast system clock, so the rails and the gap clock may be fully asynchronous to it.

Top module: `a429_word_rx`

## Requirements
- R1: A pulse on `rail_one` (encoding {one,zero}=2'b10) yields a 1 bit, and a pulse on `rail_zero` (2'b01) yields a 0 bit. A bit is taken only when the line moves from null (2'b00) to a valid rail. Both rails high (2'b11) adds no bit and does not disturb the word.
- R2: The first bit received after a gap appears at `word_data[0]`, and the 32nd appears at `word_data[31]`.
- R3: A word ends after 16 gap-clock rising edges with no bit. `word_load` is then high for exactly one system cycle, and `word_data`/`word_err` change only in that cycle. A long idle gives only one load.
- R4: If the bit count since the previous gap is not 32 (fewer, or more), `word_err` is 1 at that load.
- R5: With `par_en` high, a 32-bit word with even parity is delivered with bit 31 forced to 1 and `word_err` set to 1. A word with odd parity is delivered unchanged with `word_err` 0.
- R6: With `par_en` low, bit 31 is delivered exactly as received and parity raises no error.
- R7: `word_err` returns to 0 at the next load of a valid word. Reset (`rst` high) clears `word_err`, `word_data` and `word_load`.
- R8: After reset, bits arriving before the first completed gap are discarded and produce no load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the gap clock and the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rail_one | input | 1 | Return-to-zero rail whose pulse signals a 1 bit (asynchronous) |
| rail_zero | input | 1 | Return-to-zero rail whose pulse signals a 0 bit (asynchronous) |
| gap_clk | input | 1 | Slow timing clock used to measure the inter-word gap (asynchronous) |
| par_en | input | 1 | High enables the odd-parity check and the bit-31 error marker |
| word_load | output | 1 | One-cycle strobe marking a delivered word |
| word_data | output | 32 | Delivered word, with bit 1 of the line at index 0 |
| word_err | output | 1 | Length or parity error for the last delivered word |

## Verification
The parity assertions compare `par_en` at the port with the delivered word. They therefore assume `par_en` is held steady around each word's end, so the stimulus only changes it while the line is idle. The assertions also assume the rails hold each level for more system cycles than the synchroniser depth, and that the gap clock is far slower than the system clock. The bench uses rail pulses and nulls of six system cycles each, and a gap clock eight times slower. In-word null spans therefore cover at most two gap edges, well short of the sixteen that end a word.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  // Rail pair packed as {one, zero}
  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ZERO = 2'b01,
    RAIL_ONE  = 2'b10,
    RAIL_BAD  = 2'b11
  } rail_e;

  function automatic logic rail_is_bit(rail_e r);
    return (r == RAIL_ONE) || (r == RAIL_ZERO);
  endfunction

endpackage

// File: rtl/a429_sync.sv
module a429_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/a429_bit_recover.sv
module a429_bit_recover
  import a429_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rails,
  input  logic       gclk,
  output logic       bit_stb,
  output logic       bit_val,
  output logic       gap_tick
);
  rail_e cur, prev;
  logic  gclk_q;

  assign cur = rail_e'(rails);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= RAIL_NULL;
      gclk_q <= 1'b0;
    end else begin
      prev   <= cur;
      gclk_q <= gclk;
    end
  end

  // A bit is the departure from null onto exactly one rail
  assign bit_stb  = rail_is_bit(cur) && (prev == RAIL_NULL);
  assign bit_val  = (cur == RAIL_ONE);
  assign gap_tick = gclk & ~gclk_q;
endmodule

// File: rtl/a429_gap_timer.sv
module a429_gap_timer #(
  parameter int GAP_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic gap_tick,
  output logic gap_hit
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [GW-1:0] TOP  = GW'(GAP_TICKS);
  localparam logic [GW-1:0] LAST = GW'(GAP_TICKS - 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (bit_stb) cnt <= '0;
    else if (gap_tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

  // Fires once, on the tick that reaches TOP; saturation stops repeats
  assign gap_hit = gap_tick && !bit_stb && (cnt == LAST);
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int GAP_TICKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rail_one,
  input  logic              rail_zero,
  input  logic              gap_clk,
  input  logic              par_en,
  output logic              word_load,
  output logic [WORD_W-1:0] word_data,
  output logic              word_err
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [2:0] sync_q;
  logic       bit_stb, bit_val, gap_tick, gap_hit;

  a429_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rail_one, rail_zero, gap_clk}),
    .q   (sync_q)
  );

  a429_bit_recover u_rec (
    .clk      (clk),
    .rst      (rst),
    .rails    (sync_q[2:1]),
    .gclk     (sync_q[0]),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .gap_tick (gap_tick)
  );

  a429_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .gap_tick (gap_tick),
    .gap_hit  (gap_hit)
  );

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              armed;
  logic              par_fail, len_bad;
  logic [WORD_W-1:0] deliver;

  always_comb begin
    par_fail = par_en && !(^shreg);
    len_bad  = (bit_cnt != CNT_FULL);
    deliver  = shreg;
    if (par_fail) deliver[WORD_W-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      armed     <= 1'b0;
      word_load <= 1'b0;
      word_data <= '0;
      word_err  <= 1'b0;
    end else begin
      word_load <= 1'b0;
      if (gap_hit) begin
        bit_cnt <= '0;
        armed   <= 1'b1;
        if (armed) begin
          word_load <= 1'b1;
          word_data <= deliver;
          word_err  <= len_bad || par_fail;
        end
      end else if (bit_stb && armed) begin
        // Newest bit enters at the top, so the first bit settles at index 0
        shreg <= {bit_val, shreg[WORD_W-1:1]};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              par_en,
  input logic              word_load,
  input logic [WORD_W-1:0] word_data,
  input logic              word_err,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              armed
);
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    word_load |=> !word_load); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_load |-> $stable(word_data)); // R3

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_load |-> $stable(word_err)); // R7

  AST_LEN_ERR: assert property (@(posedge clk) disable iff (rst)
    (word_load && $past(bit_cnt) != CNT_W'(WORD_W)) |-> word_err); // R4

  AST_PAR_MARK: assert property (@(posedge clk) disable iff (rst)
    (word_load && par_en && !word_data[WORD_W-1]) |-> (^word_data)); // R5

  AST_PAR_OFF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (word_load && !par_en && $past(bit_cnt) == CNT_W'(WORD_W)) |-> !word_err); // R6

  AST_NO_LOAD_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !$past(armed) |-> !word_load); // R8
endmodule

bind a429_word_rx a429_word_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .par_en    (par_en),
  .word_load (word_load),
  .word_data (word_data),
  .word_err  (word_err),
  .bit_cnt   (bit_cnt),
  .armed     (armed)
);

// File: tb/tb_a429_word_rx.sv
module tb_a429_word_rx;
  logic        clk = 0, rst = 1;
  logic        rail_one = 0, rail_zero = 0, gap_clk = 0, par_en = 0;
  logic        word_load, word_err;
  logic [31:0] word_data;

  always #4 clk = ~clk;        // 125 MHz
  always #32 gap_clk = ~gap_clk;

  a429_word_rx dut (
    .clk(clk), .rst(rst), .rail_one(rail_one), .rail_zero(rail_zero),
    .gap_clk(gap_clk), .par_en(par_en),
    .word_load(word_load), .word_data(word_data), .word_err(word_err)
  );

  typedef struct {
    logic [31:0] d;
    logic        e;
    bit          cd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0, n_load = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare on every load
  always @(negedge clk) begin
    exp_t x;
    if (!rst && word_load) begin
      n_load++;
      if (q.size() == 0) check(0, "R3 unexpected load", word_data, 32'h0);
      else begin
        x = q.pop_front();
        check(word_err == x.e, {x.tag, " error flag"}, 32'(word_err), 32'(x.e));
        if (x.cd) check(word_data == x.d, {x.tag, " data"}, word_data, x.d);
      end
    end
  end

  task automatic send_bit(bit b);
    @(negedge clk);
    if (b) rail_one = 1; else rail_zero = 1;
    repeat (6) @(negedge clk);
    rail_one = 0; rail_zero = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_bits(logic [39:0] v, int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic send_invalid();
    @(negedge clk);
    rail_one = 1; rail_zero = 1;
    repeat (6) @(negedge clk);
    rail_one = 0; rail_zero = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic gap_wait();
    repeat (200) @(negedge clk);
  endtask

  // Driver: push the expected result, then drive the word and its gap
  task automatic push_exp(logic [39:0] v, int n, string tag);
    exp_t x;
    x.tag = tag;
    if (n == 32) begin
      x.d = v[31:0];
      x.e = par_en && !(^v[31:0]);
      if (x.e) x.d[31] = 1'b1;
      x.cd = 1;
    end else begin
      x.d = '0; x.e = 1'b1; x.cd = 0;
    end
    q.push_back(x);
  endtask

  task automatic word(logic [39:0] v, int n, string tag);
    push_exp(v, n, tag);
    send_bits(v, n);
    gap_wait();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ld;
    repeat (5) @(negedge clk);
    check(word_load == 0, "R7 reset load", 32'(word_load), 0);
    check(word_err == 0, "R7 reset err", 32'(word_err), 0);
    check(word_data == 0, "R7 reset data", word_data, 0);
    rst = 0;

    // R8: partial word straight after reset is dropped
    send_bits(40'h3FF, 10);
    gap_wait();
    check(n_load == 0, "R8 no load before first gap", n_load, 0);

    // R1/R2: plain words, parity off
    word(40'hA5A5_0001, 32, "R2 bit order");
    word(40'h0000_0001, 32, "R2 first bit at index 0");
    word(40'h8000_0000, 32, "R2 last bit at index 31");
    word(40'hFFFF_FFFF, 32, "R1 all ones");
    word(40'h0000_0000, 32, "R1 all zeros");

    // R6: even parity passes untouched when parity off
    word(40'h0000_0003, 32, "R6 parity off");

    // R5: parity on
    par_en = 1;
    gap_wait();
    word(40'hA5A5_0001, 32, "R5 odd parity ok");
    word(40'h0000_0003, 32, "R5 parity fail marker");
    word(40'h8000_0001, 32, "R5 parity fail bit31 already set");
    // R7: error clears on next valid word
    word(40'h1234_5678, 32, "R7 clear on valid word");
    par_en = 0;
    gap_wait();

    // R4: length errors
    word(40'h000F_FFFF, 20, "R4 short word");
    word(40'hC0_0000_0001, 32, "R7 clear after short");
    word(40'h7_FFFF_FFFF, 35, "R4 long word");

    // R1: both-high state ignored mid-word
    push_exp(40'hDEAD_BEEF, 32, "R1 invalid rails ignored");
    send_bits(40'hBEEF, 16);
    send_invalid();
    send_bits(40'hDEAD, 16);
    gap_wait();

    // R3: long idle yields no extra load
    ld = n_load;
    repeat (1000) @(negedge clk);
    check(n_load == ld, "R3 single load per gap", n_load, ld);

    // R7: reset clears a standing error
    word(40'h3, 2, "R4 two-bit word");
    send_bits(40'hFFF, 12);
    @(negedge clk); rst = 1;
    repeat (4) @(negedge clk);
    check(word_err == 0, "R7 reset clears err", 32'(word_err), 0);
    check(word_data == 0, "R7 reset clears data", word_data, 0);
    rst = 0;
    // R8: rest of interrupted word arrives before first gap
    ld = n_load;
    send_bits(40'hF_FFFF, 20);
    gap_wait();
    check(n_load == ld, "R8 partial after reset dropped", n_load, ld);
    word(40'h5555_AAAA, 32, "R8 first word after arming");

    gap_wait();
    check(q.size() == 0, "R3 all expected loads seen", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule